// File: doc/BRIEF.md
# Image Descriptor Line Address Generator

This block sits in the control unit of a line-parallel image processor. It holds a table of eight image descriptors. Each descriptor has a base address, a line counter, a page counter (the page picks a bit plane) and a per-descriptor count of lines in each plane. On request it turns one descriptor into an absolute 10-bit line address for an image memory of 1024 words, where each word holds one line of one bit plane. The address is base + page × lines_per_plane + line, taken modulo 1024.

Program commands arrive one per cycle on a small command port. A command can load a descriptor's base or plane size, clear a counter, or step a counter by an amount carried in the command. Two further loop counters, M and N, do not take part in addressing. They can be loaded, stepped and tested, and a test drives equal and zero flags in the same cycle. Any step that carries out of its counter wraps and sets a sticky overflow flag. Only a reset clears that flag.

Top module: `img_line_addr_gen`

## Requirements
- R1: After reset, every descriptor field, both loop counters, the address output, the address strobe and all overflow flags are zero.
- R2: A command with opcode 7 (emit) and descriptor index d sets `addr_o` on the next clock edge to (base + page × lines_per_plane + line) mod 1024 of descriptor d, using the values held before that edge. `addr_vld_o` is high for exactly that one cycle. At all other times `addr_o` holds its value.
- R3: Opcode 3 clears the line counter of the indexed descriptor. Opcode 4 adds `cmd_val_i[9:0]` to it, modulo 1024.
- R4: Opcode 5 clears the page counter of the indexed descriptor. Opcode 6 adds `cmd_val_i[2:0]` to it, modulo 8.
- R5: Opcode 1 loads the base from `cmd_val_i` and opcode 2 loads lines_per_plane from `cmd_val_i`. Both act on the indexed descriptor only, and all other descriptors keep their fields.
- R6: Opcode 8 loads `cmd_val_i[7:0]` into the loop counter picked by `cmd_ctr_i` (0 = M, 1 = N). Opcode 9 adds `cmd_val_i[7:0]` to that counter modulo 256. The other counter is unchanged.
- R7: While an opcode 10 (test) command is present, `test_eq_o` is high when the picked counter equals `cmd_val_i[7:0]`, and `test_zero_o` is high when that counter is zero. Both flags are combinational from the command and are low when no test is present.
- R8: A line or page step that carries out sets `desc_ovf_o[d]`. A loop counter step that carries out sets `ctr_ovf_o[c]` (bit 0 = M, bit 1 = N). Each flag stays set until reset.
- R9: While `cmd_valid_i` is low, no state changes and `addr_vld_o` stays low. Opcodes 0 and 11 to 15 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | A command is present this cycle |
| cmd_op_i | input | 4 | Opcode (see R2 to R9) |
| cmd_desc_i | input | 3 | Descriptor index |
| cmd_ctr_i | input | 1 | Loop counter select, 0 = M, 1 = N |
| cmd_val_i | input | 10 | Load value, step amount or test value |
| addr_o | output | 10 | Registered absolute line address |
| addr_vld_o | output | 1 | Strobe for a newly emitted address |
| test_eq_o | output | 1 | Test result: counter equals value |
| test_zero_o | output | 1 | Test result: counter is zero |
| desc_ovf_o | output | 8 | Sticky overflow flag for each descriptor |
| ctr_ovf_o | output | 2 | Sticky overflow flags for M and N |

## Verification
Because the address is registered, the strobe for an emit command is still visible in the cycle where the next command, often a step on the same descriptor or a loop counter test, takes effect. The bench issues an emit and follows it at once with a line step on that descriptor, then with a counter test. It checks that the visible address still carries the pre-step value, that the combinational test flags are correct while the strobe is high, and that a later emit shows the stepped address.

// File: rtl/idg_pkg.sv
package idg_pkg;
    typedef enum logic [3:0] {
        OP_NOP      = 4'd0,
        OP_SET_BASE = 4'd1,
        OP_SET_LPP  = 4'd2,
        OP_LINE_CLR = 4'd3,
        OP_LINE_ADD = 4'd4,
        OP_PAGE_CLR = 4'd5,
        OP_PAGE_ADD = 4'd6,
        OP_EMIT     = 4'd7,
        OP_CTR_LOAD = 4'd8,
        OP_CTR_ADD  = 4'd9,
        OP_CTR_TEST = 4'd10
    } idg_op_e;
endpackage

// File: rtl/idg_desc_slot.sv
module idg_desc_slot
    import idg_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int PAGE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic [3:0]        op_i,
    input  logic [ADDR_W-1:0] val_i,
    output logic [ADDR_W-1:0] base_o,
    output logic [ADDR_W-1:0] lpp_o,
    output logic [ADDR_W-1:0] line_o,
    output logic [PAGE_W-1:0] page_o,
    output logic              ovf_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] lpp;
        logic [ADDR_W-1:0] line;
        logic [PAGE_W-1:0] page;
        logic              ovf;
    } slot_t;

    slot_t st_d, st_q;
    logic [ADDR_W:0] line_sum;
    logic [PAGE_W:0] page_sum;

    assign line_sum = {1'b0, st_q.line} + {1'b0, val_i};
    assign page_sum = {1'b0, st_q.page} + {1'b0, val_i[PAGE_W-1:0]};

    always_comb begin
        st_d = st_q;
        if (sel_i) begin
            case (op_i)
                OP_SET_BASE: st_d.base = val_i;
                OP_SET_LPP:  st_d.lpp  = val_i;
                OP_LINE_CLR: st_d.line = '0;
                OP_LINE_ADD: begin
                    st_d.line = line_sum[ADDR_W-1:0];
                    if (line_sum[ADDR_W]) st_d.ovf = 1'b1;
                end
                OP_PAGE_CLR: st_d.page = '0;
                OP_PAGE_ADD: begin
                    st_d.page = page_sum[PAGE_W-1:0];
                    if (page_sum[PAGE_W]) st_d.ovf = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign base_o = st_q.base;
    assign lpp_o  = st_q.lpp;
    assign line_o = st_q.line;
    assign page_o = st_q.page;
    assign ovf_o  = st_q.ovf;

    AST_LINE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && op_i == OP_LINE_CLR) |=> (line_o == '0)); // R3
    AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && op_i == OP_PAGE_ADD) |=> (page_o == $past(page_o + val_i[PAGE_W-1:0]))); // R4
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o); // R8
    AST_UNSEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_i |=> ($stable(base_o) && $stable(lpp_o) && $stable(line_o) && $stable(page_o))); // R5
endmodule

// File: rtl/idg_loop_ctr.sv
module idg_loop_ctr
    import idg_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_i,
    input  logic [3:0]       op_i,
    input  logic [CNT_W-1:0] val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o,
    output logic             eq_o,
    output logic             zero_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } ctr_t;

    ctr_t st_d, st_q;
    logic [CNT_W:0] sum;
    logic           testing;

    assign sum     = {1'b0, st_q.cnt} + {1'b0, val_i};
    assign testing = sel_i && (op_i == OP_CTR_TEST);

    always_comb begin
        st_d = st_q;
        if (sel_i) begin
            case (op_i)
                OP_CTR_LOAD: st_d.cnt = val_i;
                OP_CTR_ADD: begin
                    st_d.cnt = sum[CNT_W-1:0];
                    if (sum[CNT_W]) st_d.ovf = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign ovf_o  = st_q.ovf;
    assign eq_o   = testing && (st_q.cnt == val_i);
    assign zero_o = testing && (st_q.cnt == '0);

    AST_CTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && op_i == OP_CTR_LOAD) |=> (cnt_o == $past(val_i))); // R6
    AST_TEST_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        testing |=> $stable(cnt_o)); // R7
    AST_CTR_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o); // R8
endmodule

// File: rtl/idg_addr_calc.sv
module idg_addr_calc #(
    parameter int NUM_DESC = 8,
    parameter int ADDR_W   = 10,
    parameter int PAGE_W   = 3,
    parameter int IDX_W    = 3
) (
    input  logic [IDX_W-1:0]                 idx_i,
    input  logic [NUM_DESC-1:0][ADDR_W-1:0]  base_i,
    input  logic [NUM_DESC-1:0][ADDR_W-1:0]  lpp_i,
    input  logic [NUM_DESC-1:0][ADDR_W-1:0]  line_i,
    input  logic [NUM_DESC-1:0][PAGE_W-1:0]  page_i,
    output logic [ADDR_W-1:0]                addr_o
);
    localparam int PROD_W = ADDR_W + PAGE_W;

    logic [PROD_W-1:0] prod;

    always_comb begin
        prod   = {{ADDR_W{1'b0}}, page_i[idx_i]} * {{PAGE_W{1'b0}}, lpp_i[idx_i]};
        addr_o = base_i[idx_i] + prod[ADDR_W-1:0] + line_i[idx_i];
    end
endmodule

// File: rtl/img_line_addr_gen.sv
module img_line_addr_gen
    import idg_pkg::*;
#(
    parameter int NUM_DESC = 8,
    parameter int ADDR_W   = 10,
    parameter int PAGE_W   = 3,
    parameter int CNT_W    = 8,
    parameter int NUM_CTR  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid_i,
    input  logic [3:0]          cmd_op_i,
    input  logic [$clog2(NUM_DESC)-1:0] cmd_desc_i,
    input  logic [$clog2(NUM_CTR)-1:0]  cmd_ctr_i,
    input  logic [ADDR_W-1:0]   cmd_val_i,
    output logic [ADDR_W-1:0]   addr_o,
    output logic                addr_vld_o,
    output logic                test_eq_o,
    output logic                test_zero_o,
    output logic [NUM_DESC-1:0] desc_ovf_o,
    output logic [NUM_CTR-1:0]  ctr_ovf_o
);
    localparam int IDX_W = $clog2(NUM_DESC);
    localparam int SEL_W = $clog2(NUM_CTR);

    logic [NUM_DESC-1:0][ADDR_W-1:0] base_w, lpp_w, line_w;
    logic [NUM_DESC-1:0][PAGE_W-1:0] page_w;
    logic [NUM_CTR-1:0][CNT_W-1:0]   cnt_w;
    logic [NUM_CTR-1:0]              eq_w, zero_w;
    logic [ADDR_W-1:0]               calc_addr;

    for (genvar g = 0; g < NUM_DESC; g++) begin : g_slot
        idg_desc_slot #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) slot_i (
            .clk   (clk),
            .rst_n (rst_n),
            .sel_i (cmd_valid_i && (cmd_desc_i == IDX_W'(g))),
            .op_i  (cmd_op_i),
            .val_i (cmd_val_i),
            .base_o(base_w[g]),
            .lpp_o (lpp_w[g]),
            .line_o(line_w[g]),
            .page_o(page_w[g]),
            .ovf_o (desc_ovf_o[g])
        );
    end

    for (genvar c = 0; c < NUM_CTR; c++) begin : g_ctr
        idg_loop_ctr #(.CNT_W(CNT_W)) ctr_i (
            .clk   (clk),
            .rst_n (rst_n),
            .sel_i (cmd_valid_i && (cmd_ctr_i == SEL_W'(c))),
            .op_i  (cmd_op_i),
            .val_i (cmd_val_i[CNT_W-1:0]),
            .cnt_o (cnt_w[c]),
            .ovf_o (ctr_ovf_o[c]),
            .eq_o  (eq_w[c]),
            .zero_o(zero_w[c])
        );
    end

    idg_addr_calc #(
        .NUM_DESC(NUM_DESC), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .IDX_W(IDX_W)
    ) calc_i (
        .idx_i (cmd_desc_i),
        .base_i(base_w),
        .lpp_i (lpp_w),
        .line_i(line_w),
        .page_i(page_w),
        .addr_o(calc_addr)
    );

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              vld;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d     = out_q;
        out_d.vld = cmd_valid_i && (cmd_op_i == OP_EMIT);
        if (out_d.vld) out_d.addr = calc_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign addr_o      = out_q.addr;
    assign addr_vld_o  = out_q.vld;
    assign test_eq_o   = |eq_w;
    assign test_zero_o = |zero_w;

    AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        addr_vld_o |-> $past(cmd_valid_i && cmd_op_i == OP_EMIT)); // R2
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_vld_o |-> $stable(addr_o)); // R2
    AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid_i |=> !addr_vld_o); // R9
    AST_FLAGS_ONE_CTR: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(eq_w) <= 1); // R7
endmodule

// File: tb/img_line_addr_gen_tb.sv
module img_line_addr_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid_i = 1'b0;
    logic [3:0] cmd_op_i = 4'd0;
    logic [2:0] cmd_desc_i = 3'd0;
    logic       cmd_ctr_i = 1'b0;
    logic [9:0] cmd_val_i = 10'd0;
    logic [9:0] addr_o;
    logic       addr_vld_o, test_eq_o, test_zero_o;
    logic [7:0] desc_ovf_o;
    logic [1:0] ctr_ovf_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    logic seen_eq, seen_zero, seen_vld;

    always #2 clk = ~clk;

    img_line_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
        .cmd_desc_i(cmd_desc_i), .cmd_ctr_i(cmd_ctr_i), .cmd_val_i(cmd_val_i),
        .addr_o(addr_o), .addr_vld_o(addr_vld_o), .test_eq_o(test_eq_o),
        .test_zero_o(test_zero_o), .desc_ovf_o(desc_ovf_o), .ctr_ovf_o(ctr_ovf_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive at negedge, capture combinational flags, then step past the edge.
    task automatic issue(input bit v, input int op, input int d, input int c, input int val);
        @(negedge clk);
        cmd_valid_i = v;
        cmd_op_i    = 4'(op);
        cmd_desc_i  = 3'(d);
        cmd_ctr_i   = 1'(c);
        cmd_val_i   = 10'(val);
        #1;
        seen_eq   = test_eq_o;
        seen_zero = test_zero_o;
        seen_vld  = addr_vld_o;
        @(posedge clk);
        #1;
        cmd_valid_i = 1'b0;
        cmd_op_i    = 4'd0;
    endtask

    task automatic t_reset();
        check("R1 addr", int'(addr_o), 0);
        check("R1 vld", int'(addr_vld_o), 0);
        check("R1 desc_ovf", int'(desc_ovf_o), 0);
        check("R1 ctr_ovf", int'(ctr_ovf_o), 0);
        check("R1 flags", int'({test_eq_o, test_zero_o}), 0);
        issue(1, 7, 6, 0, 0);
        check("R1 emitted fields zero", int'(addr_o), 0);
    endtask

    task automatic t_addr();
        issue(1, 1, 2, 0, 100);
        issue(1, 2, 2, 0, 64);
        issue(1, 4, 2, 0, 5);
        issue(1, 6, 2, 0, 3);
        issue(1, 7, 2, 0, 0);
        check("R2 addr base+page*lpp+line", int'(addr_o), 297);
        check("R2 strobe", int'(addr_vld_o), 1);
        issue(0, 0, 0, 0, 0);
        check("R2 strobe one cycle", int'(addr_vld_o), 0);
        check("R2 addr holds", int'(addr_o), 297);
        issue(1, 7, 3, 0, 0);
        check("R5 other descriptor untouched", int'(addr_o), 0);
    endtask

    task automatic t_wrap();
        issue(1, 1, 1, 0, 1000);
        issue(1, 2, 1, 0, 512);
        issue(1, 6, 1, 0, 2);
        issue(1, 4, 1, 0, 30);
        issue(1, 7, 1, 0, 0);
        check("R2 address modulo 1024", int'(addr_o), 6);
        check("R8 no overflow from address sum", int'(desc_ovf_o), 0);
    endtask

    task automatic t_line_ovf();
        issue(1, 4, 4, 0, 1000);
        issue(1, 4, 4, 0, 30);
        issue(1, 7, 4, 0, 0);
        check("R3 line wraps", int'(addr_o), 6);
        check("R8 line overflow flag", int'(desc_ovf_o), 'h10);
        issue(1, 3, 4, 0, 0);
        issue(1, 7, 4, 0, 0);
        check("R3 line clear", int'(addr_o), 0);
        check("R8 flag sticky after clear", int'(desc_ovf_o), 'h10);
    endtask

    task automatic t_page_ovf();
        issue(1, 2, 5, 0, 10);
        issue(1, 6, 5, 0, 6);
        issue(1, 6, 5, 0, 3);
        issue(1, 7, 5, 0, 0);
        check("R4 page wraps mod 8", int'(addr_o), 10);
        check("R8 page overflow flag", int'(desc_ovf_o), 'h30);
        issue(1, 5, 5, 0, 0);
        issue(1, 7, 5, 0, 0);
        check("R4 page clear", int'(addr_o), 0);
    endtask

    task automatic t_invalid();
        issue(0, 4, 2, 0, 7);
        issue(0, 7, 2, 0, 0);
        check("R9 no strobe when invalid", int'(addr_vld_o), 0);
        issue(1, 12, 2, 0, 7);
        issue(1, 0, 2, 0, 7);
        issue(1, 7, 2, 0, 0);
        check("R9 invalid and unused opcodes ignored", int'(addr_o), 297);
    endtask

    task automatic t_ctr();
        issue(1, 8, 0, 0, 5);
        issue(1, 10, 0, 0, 5);
        check("R7 M eq", int'(seen_eq), 1);
        check("R7 M not zero", int'(seen_zero), 0);
        issue(1, 8, 0, 1, 0);
        issue(1, 10, 0, 1, 3);
        check("R7 N ne", int'(seen_eq), 0);
        check("R7 N zero", int'(seen_zero), 1);
        issue(1, 9, 0, 0, 250);
        issue(1, 10, 0, 0, 255);
        check("R6 M step", int'(seen_eq), 1);
        check("R8 no ctr overflow yet", int'(ctr_ovf_o), 0);
        issue(1, 9, 0, 0, 2);
        issue(1, 10, 0, 0, 1);
        check("R6 M wraps mod 256", int'(seen_eq), 1);
        check("R8 M overflow flag", int'(ctr_ovf_o), 1);
        issue(1, 10, 0, 1, 0);
        check("R6 N unchanged", int'({seen_eq, seen_zero}), 3);
        issue(1, 0, 0, 0, 1);
        check("R7 flags low without test", int'({seen_eq, seen_zero}), 0);
        issue(0, 10, 0, 0, 1);
        check("R7 flags low when invalid", int'({seen_eq, seen_zero}), 0);
    endtask

    task automatic t_same_cycle();
        issue(1, 7, 2, 0, 0);
        check("R2 pre-step emit", int'(addr_o), 297);
        issue(1, 4, 2, 0, 1);
        check("R3 strobe seen during step", int'(seen_vld), 1);
        check("R2 addr not yet stepped", int'(addr_o), 297);
        issue(1, 7, 2, 0, 0);
        check("R3 stepped address", int'(addr_o), 298);
        issue(1, 10, 0, 0, 1);
        check("R7 test during strobe", int'({seen_vld, seen_eq}), 3);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_addr();
        t_wrap();
        t_line_ovf();
        t_page_ovf();
        t_invalid();
        t_ctr();
        t_same_cycle();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule